// File: doc/BRIEF.md
# Keypad Event Queue

This block buffers keypad press and release events in a sixteen-entry circular queue until the host reads them. Each incoming event is one byte. The key code sits in bits 6:0, and bit 7 is taken from the event's state input (1 for one state, 0 for the other). Only events the queue accepts set the keypad interrupt flag. An event that arrives while the queue is full is lost, and it latches the FIFO-overflow error together with the error interrupt flag. While both of those are set, every later event is dropped silently.

The host has two read paths. The consuming read shows, on `pop_byte`, what a pop returns in the current cycle. A pop first moves the head forward one slot and then returns the entry at the new head. When one entry or fewer is held, it returns zero and changes nothing. The repeat read takes an index and returns the entry that many slots past the head, or zero when the index is not below the fill level. It never changes the queue. A configuration write empties the queue and clears both interrupt flags. A status clear clears the flags only.

The event input uses valid/ready. `evt_ready` is held high at all times, so the block never applies back-pressure. An event is accepted or dropped in the cycle its `evt_valid` is high, and the sender must not hold or retry it.

Top module: `keyq_top`

## Requirements
- R1: An accepted event is written as {state, code} into slot (head + length) mod 16, and the length grows by one.
- R2: Every accepted event sets the keypad flag `kp_flag`. A status clear in the same cycle does not prevent the set.
- R3: An event that arrives with 16 entries held is dropped, and it sets `err_bits` bit 6 and `err_flag`.
- R4: While `err_flag` and `err_bits` bit 6 are both set, events are discarded and neither the queue nor any flag changes because of them.
- R5: A pop while the length is 0 or 1 returns 0x00 and leaves the head and the length unchanged.
- R6: A pop while the length is 2 or more advances the head by one modulo 16, lowers the length by one, and returns the entry at the new head.
- R7: A repeat read at index i returns the entry at (head + i) mod 16 when i is below the length, and 0x00 otherwise. It leaves the queue unchanged.
- R8: `cfg_wr` sets the head and the length to zero and clears `kp_flag` and `err_flag`. An event in the same cycle is ignored.
- R9: A push and an effective pop in the same cycle both take effect, and the length stays the same.
- R10: `err_bits` bit 2 (key overflow) and every bit other than 6 stay zero. Bit 6 stays set until reset.
- R11: `stat_clr` clears `kp_flag` and `err_flag`, which lets events be accepted again.
- R12: `evt_ready` is high whenever reset is released. Slot and head arithmetic wraps modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_ready | output | 1 | Always high; no back-pressure |
| evt_code | input | 7 | Key code |
| evt_state | input | 1 | Press/release state, becomes bit 7 |
| pop_rd | input | 1 | Consuming read this cycle |
| pop_byte | output | 8 | Byte the consuming read returns |
| peek_idx | input | IDX_W | Repeat-read index from head |
| peek_byte | output | 8 | Byte at the repeat-read index |
| cfg_wr | input | 1 | Configuration write: empty queue, clear flags |
| stat_clr | input | 1 | Clear interrupt flags |
| kp_flag | output | 1 | Keypad interrupt flag |
| err_flag | output | 1 | Error interrupt flag |
| err_bits | output | 8 | Error byte; bit 6 is FIFO overflow |

## Verification
The hardest state to reach is the silenced mode, where an overflow has latched and events must vanish without any trace. The stimulus fills all sixteen slots and sends one more event to trigger the overflow. It then pops a few entries so that free slots exist, which means a drop can only come from the silence rule and not from a full queue. It then sends more events and shows through repeat reads that the slot past the fill level still reads zero. A status clear follows, and the next event must land in a slot that wraps past 15 back to 0.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
  typedef logic [7:0] evt_byte_t;

  localparam int unsigned OVF_BIT = 6;

  function automatic evt_byte_t pack_evt(input logic [6:0] code, input logic state);
    return {state, code};
  endfunction
endpackage

// File: rtl/keyq_store.sv
module keyq_store #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PTR_W-1:0]    wr_addr,
  input  keyq_pkg::evt_byte_t wr_data,
  input  logic [PTR_W-1:0]    ra_addr,
  output keyq_pkg::evt_byte_t ra_data,
  input  logic [PTR_W-1:0]    rb_addr,
  output keyq_pkg::evt_byte_t rb_data
);
  keyq_pkg::evt_byte_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && (wr_addr == PTR_W'(g)))
        slot_q[g] <= wr_data;
    end
  end

  assign ra_data = slot_q[ra_addr];
  assign rb_data = slot_q[rb_addr];
endmodule

// File: rtl/keyq_ptr.sv
module keyq_ptr #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             clr,
  input  logic             silent,
  output logic             push_ok,
  output logic             ovf_hit,
  output logic [PTR_W-1:0] head,
  output logic [LEN_W-1:0] fill,
  output logic [PTR_W-1:0] wr_slot
);
  logic [PTR_W-1:0] head_q;
  logic [LEN_W-1:0] fill_q;
  logic             full, pop_ok;

  assign full    = (fill_q == LEN_W'(DEPTH));
  assign push_ok = push_req && !clr && !silent && !full;
  assign ovf_hit = push_req && !clr && !silent && full;
  assign pop_ok  = pop_req && !clr && (fill_q > LEN_W'(1));
  assign wr_slot = head_q + fill_q[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      head_q <= '0;
      fill_q <= '0;
    end else begin
      head_q <= head_q + PTR_W'(pop_ok);
      fill_q <= fill_q + LEN_W'(push_ok) - LEN_W'(pop_ok);
    end
  end

  assign head = head_q;
  assign fill = fill_q;

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= LEN_W'(DEPTH));
  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_req) |=> fill_q == $past(fill_q) + LEN_W'(1));
  assert_short_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !clr && fill_q <= LEN_W'(1)) |=> ($stable(fill_q) && $stable(head_q)));
  assert_pop_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !clr && fill_q > LEN_W'(1)) |=> head_q == $past(head_q) + PTR_W'(1));
  assert_both_same_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_req && fill_q > LEN_W'(1)) |=> $stable(fill_q));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_q == '0 && head_q == '0));
endmodule

// File: rtl/keyq_flags.sv
module keyq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_ok,
  input  logic       ovf_hit,
  input  logic       evt_valid,
  input  logic       stat_clr,
  input  logic       cfg_wr,
  output logic       silent,
  output logic       kp_flag,
  output logic       err_flag,
  output logic [7:0] err_bits
);
  logic kp_q, err_q, ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kp_q  <= 1'b0;
      err_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (cfg_wr) begin
      kp_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      kp_q  <= push_ok || (kp_q && !stat_clr);
      err_q <= ovf_hit || (err_q && !stat_clr);
      ovf_q <= ovf_q || ovf_hit;
    end
  end

  assign silent   = err_q && ovf_q;
  assign kp_flag  = kp_q;
  assign err_flag = err_q;
  always_comb begin
    err_bits = '0;
    err_bits[keyq_pkg::OVF_BIT] = ovf_q;
  end

  assert_kp_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !cfg_wr) |=> kp_q);
  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && !cfg_wr) |=> (err_q && ovf_q));
  assert_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (silent && evt_valid && !stat_clr && !cfg_wr) |=> ($stable(kp_q) && $stable(err_q)));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/keyq_top.sv
module keyq_top #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [6:0]       evt_code,
  input  logic             evt_state,
  input  logic             pop_rd,
  output logic [7:0]       pop_byte,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [7:0]       peek_byte,
  input  logic             cfg_wr,
  input  logic             stat_clr,
  output logic             kp_flag,
  output logic             err_flag,
  output logic [7:0]       err_bits
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LEN_W = PTR_W + 1;
  localparam int CMP_W = (IDX_W > LEN_W) ? IDX_W : LEN_W;

  logic                push_ok, ovf_hit, silent;
  logic [PTR_W-1:0]    head, wr_slot;
  logic [LEN_W-1:0]    fill;
  keyq_pkg::evt_byte_t pop_raw, peek_raw;

  assign evt_ready = 1'b1;

  keyq_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push_req(evt_valid), .pop_req(pop_rd),
    .clr(cfg_wr), .silent(silent), .push_ok(push_ok), .ovf_hit(ovf_hit),
    .head(head), .fill(fill), .wr_slot(wr_slot)
  );

  keyq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_addr(wr_slot),
    .wr_data(keyq_pkg::pack_evt(evt_code, evt_state)),
    .ra_addr(head + PTR_W'(1)), .ra_data(pop_raw),
    .rb_addr(head + peek_idx[PTR_W-1:0]), .rb_data(peek_raw)
  );

  keyq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .ovf_hit(ovf_hit),
    .evt_valid(evt_valid), .stat_clr(stat_clr), .cfg_wr(cfg_wr),
    .silent(silent), .kp_flag(kp_flag), .err_flag(err_flag), .err_bits(err_bits)
  );

  assign pop_byte  = (fill > LEN_W'(1)) ? pop_raw : 8'h00;
  assign peek_byte = (CMP_W'(peek_idx) < CMP_W'(fill)) ? peek_raw : 8'h00;

  assert_ready_R12: assert property (@(posedge clk) disable iff (!rst_n) evt_ready);
endmodule

// File: tb/keyq_top_tb.sv
`timescale 1ns/100ps
module keyq_top_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 0, evt_state = 0, pop_rd = 0, cfg_wr = 0, stat_clr = 0;
  logic [6:0] evt_code = '0;
  logic [7:0] peek_idx = '0;
  logic evt_ready, kp_flag, err_flag;
  logic [7:0] pop_byte, peek_byte, err_bits;

  int errs = 0, checks = 0;
  bit finished = 0;

  logic [7:0] mq [16];
  int mstart = 0, mlen = 0;
  bit mkp = 0, merr = 0, movf = 0;

  always #2 clk = ~clk;

  keyq_top u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [6:0] c, input bit s,
                     input bit p, input bit cw, input bit sc);
    bit silent, full, pok, acc, ovf;
    int exp_pop;
    @(negedge clk);
    evt_valid = v; evt_code = c; evt_state = s; pop_rd = p; cfg_wr = cw; stat_clr = sc;
    #1;
    exp_pop = (mlen > 1) ? mq[(mstart + 1) % 16] : 0;
    if (p) chk(pop_byte == exp_pop[7:0], (mlen > 1) ? "R6 pop data" : "R5 short pop",
               pop_byte, exp_pop);
    silent = merr && movf;
    full = (mlen == 16);
    if (cw) begin
      mstart = 0; mlen = 0; mkp = 0; merr = 0;
    end else begin
      pok = p && (mlen > 1);
      acc = v && !silent && !full;
      ovf = v && !silent && full;
      if (acc) mq[(mstart + mlen) % 16] = {s, c};
      mstart = (mstart + (pok ? 1 : 0)) % 16;
      mlen = mlen + (acc ? 1 : 0) - (pok ? 1 : 0);
      if (sc) begin mkp = 0; merr = 0; end
      if (acc) mkp = 1;
      if (ovf) begin merr = 1; movf = 1; end
    end
    @(negedge clk);
    evt_valid = 0; pop_rd = 0; cfg_wr = 0; stat_clr = 0;
  endtask

  task automatic peek_chk(input int idx, input string tag);
    int exp;
    @(negedge clk);
    peek_idx = idx[7:0];
    #1;
    exp = (idx < mlen) ? mq[(mstart + idx) % 16] : 0;
    chk(peek_byte == exp[7:0], tag, peek_byte, exp);
  endtask

  task automatic flags_chk(input string tag);
    #1;
    chk(kp_flag == mkp, {tag, " kp_flag"}, kp_flag, mkp);
    chk(err_flag == merr, {tag, " err_flag"}, err_flag, merr);
    chk(err_bits == {1'b0, movf, 6'b0}, {tag, " err_bits R10"}, err_bits, {1'b0, movf, 6'b0});
  endtask

  task automatic t_reset;
    #1;
    chk(evt_ready == 1'b1, "R12 ready", evt_ready, 1);
    chk(pop_byte == 8'h00, "R5 empty pop byte", pop_byte, 0);
    peek_chk(0, "R7 empty peek");
    flags_chk("reset");
  endtask

  task automatic t_push_peek;
    cyc(1, 7'h15, 1, 0, 0, 0);
    cyc(1, 7'h22, 0, 0, 0, 0);
    cyc(1, 7'h3c, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) peek_chk(i, "R1 R7 peek after push");
    peek_chk(200, "R7 large index");
    flags_chk("R2 after push");
  endtask

  task automatic t_pop;
    cyc(0, 0, 0, 1, 0, 0);
    peek_chk(0, "R6 head after pop");
    peek_chk(1, "R6 second after pop");
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    peek_chk(0, "R5 head kept");
    peek_chk(1, "R5 length kept");
  endtask

  task automatic t_stat_cfg;
    cyc(0, 0, 0, 0, 0, 1);
    flags_chk("R11 stat clear");
    cyc(1, 7'h05, 0, 0, 0, 1);
    flags_chk("R2 R11 set wins");
    cyc(1, 7'h06, 0, 0, 1, 0);
    flags_chk("R8 cfg clears flags");
    peek_chk(0, "R8 queue empty");
  endtask

  task automatic t_both;
    cyc(1, 7'h11, 0, 0, 0, 0);
    cyc(1, 7'h12, 1, 0, 0, 0);
    cyc(1, 7'h13, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) peek_chk(i, "R9 push with pop");
  endtask

  task automatic t_overflow;
    cyc(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) cyc(1, 7'(i + 1), i[0], 0, 0, 0);
    peek_chk(15, "R1 last slot");
    cyc(1, 7'h7f, 1, 0, 0, 0);
    flags_chk("R3 overflow");
    peek_chk(15, "R3 queue unchanged");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 7'h40, 0, 0, 0, 0);
    cyc(1, 7'h41, 1, 0, 0, 0);
    peek_chk(13, "R4 dropped while silent");
    flags_chk("R4 flags held");
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 7'h55, 1, 0, 0, 0);
    peek_chk(13, "R12 wrapped slot");
    peek_chk(0, "R12 head after wrap");
    flags_chk("R11 unsilenced");
    for (int i = 0; i < 13; i++) cyc(0, 0, 0, 1, 0, 0);
    peek_chk(0, "R12 head wraps");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_push_peek();
    t_pop();
    t_stat_cfg();
    t_both();
    t_overflow();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errs++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule